// File: doc/BRIEF.md
# Indexed Register and Memory Window

This block is the host-facing front end of a display register space. A host issues single-cycle requests with a byte address, an access size of one, two or four bytes and write data. Most addresses go straight to a register bank. Two 32-bit words at the bottom of the space are local to the block. Word 0 is a pointer register. Word 1 is a data window. An access to the window is steered by the pointer. It reaches either video memory or another register in the bank, so a host with a narrow address range can still reach the whole space.

Sub-word accesses to 32-bit registers are resolved here. Read lanes are aligned down to bit 0. Write lanes are placed into position and come with byte enables, so the bank only has to honour the enables. Memory accesses are byte-addressed and little-endian. They are checked against the memory size before they are issued. The register bank and the memory array sit outside the block and answer combinationally in the request cycle. Read data returns one cycle after the request.

Top module: `idx_window`

## Requirements
- R1: After reset the pointer register holds 0, `h_rvalid` is 0 and `h_rdata` is 0.
- R2: Byte address 0x0 holds a 32-bit pointer register that can be read and written. A full-word write is read back unchanged.
- R3: A read request is answered by `h_rvalid` high, together with its data, in the cycle after the request. `h_rvalid` is low in the cycle after a write request and in the cycle after an idle cycle.
- R4: With pointer bit 31 set, an access to the window (byte addresses 0x4 to 0x7) reaches memory at pointer bits 30:0 plus the byte offset into the window. The bytes are taken in little-endian order.
- R5: A memory access is performed only if the memory address is at most MEM_BYTES minus the access size in bytes. Otherwise a write is dropped and a read returns 0.
- R6: With pointer bit 31 clear, a window access is performed as a register access at the pointer value plus the byte offset into the window.
- R7: A sub-word register read returns the addressed bytes shifted down to bit 0, with the upper bits zero.
- R8: A sub-word register write changes only the addressed bytes. Write-data bits above the access size are ignored.
- R9: A register access that the bank does not claim (`rb_hit` low) reads 0, and a write to it changes no register.
- R10: A redirected access whose target falls in the window word, or beyond the register address space, is unmapped: it reads 0 and writes nothing.
- R11: A register access that runs past the end of its 32-bit word, or that uses size code 3, is unmapped. Size codes are 0 for one byte, 1 for two bytes and 2 for four bytes.
- R12: The pointer register also accepts sub-word reads, with the same lane rules as any other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_req | input | 1 | Host request valid for one cycle |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_addr | input | ADDR_W | Host byte address |
| h_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| h_wdata | input | 32 | Write data, right-aligned |
| h_rdata | output | 32 | Read data, right-aligned, registered |
| h_rvalid | output | 1 | Read data valid, one cycle after the request |
| rb_req | output | 1 | Register bank access strobe |
| rb_wr | output | 1 | Register bank write |
| rb_addr | output | ADDR_W | Register byte address (low bits give the lane offset) |
| rb_be | output | 4 | Register byte enables |
| rb_wdata | output | 32 | Register write data in lane position |
| rb_rdata | input | 32 | Addressed register word |
| rb_hit | input | 1 | Bank claims the addressed word |
| mem_req | output | 1 | Memory access strobe |
| mem_wr | output | 1 | Memory write |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_size | output | 2 | Memory access size code |
| mem_wdata | output | 32 | Memory write data, byte 0 at bit 0 |
| mem_rdata | input | 32 | Memory bytes from `mem_addr` upward, little-endian |

## Verification
The bench drives the memory-bound edge from both sides. A four-byte read that ends on the last byte must return data. The same read shifted by one byte must return zero, and a write at that position must leave memory unchanged. A design that compared against the full size, or checked only the start address, would leak data or corrupt memory. Window accesses whose target points back into the window must do nothing, and so must targets that lie beyond the address space. If these were not blocked, the write would reach a register or come back as data. Sub-word writes with junk in the upper data bits, and accesses that cross a word edge, show up as a wrong byte in a later full-word read-back. Each read is sampled one cycle after its request, so an unregistered or late response shows up as a timing mismatch.

// File: rtl/idx_window_pkg.sv
// Shared constants, types and lane helpers for the indexed window front end.
// Assumes a 32-bit register word and byte addressing on the host side.
package idx_window_pkg;

    localparam int IDX_WORD = 0;  // word holding the pointer register
    localparam int WIN_WORD = 1;  // word acting as the data window

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_INDEX = 2'd1,
        TGT_BANK  = 2'd2,
        TGT_MEM   = 2'd3
    } tgt_e;

    // Bit mask covering the low bytes of an access of the given size.
    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_mask = 32'h0000_00FF;
            SZ_HALF: size_mask = 32'h0000_FFFF;
            SZ_WORD: size_mask = 32'hFFFF_FFFF;
            default: size_mask = 32'h0000_0000;
        endcase
    endfunction

    // Byte-enable pattern of an access of the given size, before shifting.
    function automatic logic [3:0] size_be(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_be = 4'b0001;
            SZ_HALF: size_be = 4'b0011;
            SZ_WORD: size_be = 4'b1111;
            default: size_be = 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/iw_route.sv
// Decides where a host access lands: pointer register, register bank,
// video memory or nowhere. Applies the redirect through the pointer, the
// memory bound, the address-space limit, the window loop guard and the
// word-crossing rule. Purely combinational; assumes MEM_BYTES >= 4.
module iw_route
    import idx_window_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int MEM_BYTES = 256,
    parameter int MEM_AW    = 8
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        size_code,
    input  logic [31:0]       index_val,
    output tgt_e              target,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [MEM_AW-1:0] mem_byte_addr
);

    localparam logic [31:0]       MEM_LIMIT = 32'(MEM_BYTES);
    localparam logic [ADDR_W-3:0] WIN_W     = (ADDR_W-2)'(WIN_WORD);
    localparam logic [ADDR_W-3:0] IDX_W     = (ADDR_W-2)'(IDX_WORD);

    logic [2:0]  nbytes;
    logic [2:0]  lane_end;
    logic        in_window;
    logic [31:0] redirect_sum;
    logic [31:0] eff;

    // Compute the effective address and classify the access.
    always_comb begin
        nbytes        = 3'd1 << size_code;
        in_window     = host_addr[ADDR_W-1:2] == WIN_W;
        redirect_sum  = {1'b0, index_val[30:0]} + 32'(host_addr[1:0]);
        eff           = in_window ? redirect_sum : 32'(host_addr);
        lane_end      = {1'b0, eff[1:0]} + nbytes;
        reg_addr      = eff[ADDR_W-1:0];
        mem_byte_addr = redirect_sum[MEM_AW-1:0];
        target        = TGT_NONE;
        if (size_code != SZ_BAD) begin
            if (in_window && index_val[31]) begin
                if (redirect_sum <= MEM_LIMIT - 32'(nbytes))
                    target = TGT_MEM;
            end else if ((eff >> ADDR_W) == 32'd0 &&
                         eff[ADDR_W-1:2] != WIN_W &&
                         lane_end <= 3'd4) begin
                target = (eff[ADDR_W-1:2] == IDX_W) ? TGT_INDEX : TGT_BANK;
            end
        end
    end

endmodule

// File: rtl/iw_lanes.sv
// Byte-lane unit for 32-bit registers: builds byte enables and positioned
// write data from a right-aligned host value, and aligns read data down to
// bit 0. Assumes the caller has already rejected word-crossing accesses.
module iw_lanes
    import idx_window_pkg::*;
(
    input  logic [1:0]  byte_off,
    input  logic [1:0]  size_code,
    input  logic [31:0] wr_data,
    input  logic [31:0] rd_word,
    output logic [3:0]  byte_en,
    output logic [31:0] wr_lanes,
    output logic [31:0] wr_bits,
    output logic [31:0] rd_aligned
);

    logic [31:0] mask;
    logic [4:0]  shift;

    // Shift masks and data by the byte offset inside the word.
    always_comb begin
        mask       = size_mask(size_code);
        shift      = {byte_off, 3'b000};
        byte_en    = size_be(size_code) << byte_off;
        wr_lanes   = (wr_data & mask) << shift;
        wr_bits    = mask << shift;
        rd_aligned = (rd_word >> shift) & mask;
    end

endmodule

// File: rtl/idx_window.sv
// Host front end with a pointer register and a data window. Window accesses
// reach video memory (pointer bit 31 set) or are redirected once into the
// register space. Requests are single-cycle. The bank and the memory answer
// combinationally in the request cycle, and read data is registered.
module idx_window
    import idx_window_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int MEM_BYTES = 256,
    parameter int MEM_AW    = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_req,
    input  logic              h_wr,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [1:0]        h_size,
    input  logic [31:0]       h_wdata,
    output logic [31:0]       h_rdata,
    output logic              h_rvalid,
    output logic              rb_req,
    output logic              rb_wr,
    output logic [ADDR_W-1:0] rb_addr,
    output logic [3:0]        rb_be,
    output logic [31:0]       rb_wdata,
    input  logic [31:0]       rb_rdata,
    input  logic              rb_hit,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);

    localparam logic [ADDR_W-3:0] WIN_W = (ADDR_W-2)'(WIN_WORD);

    tgt_e              target;
    logic [ADDR_W-1:0] eff_addr;
    logic [31:0]       idx_q;
    logic [31:0]       lane_src;
    logic [31:0]       wr_lanes;
    logic [31:0]       wr_bits;
    logic [31:0]       rd_aligned;
    logic [31:0]       rd_mux;

    iw_route #(
        .ADDR_W   (ADDR_W),
        .MEM_BYTES(MEM_BYTES),
        .MEM_AW   (MEM_AW)
    ) u_route (
        .host_addr    (h_addr),
        .size_code    (h_size),
        .index_val    (idx_q),
        .target       (target),
        .reg_addr     (eff_addr),
        .mem_byte_addr(mem_addr)
    );

    iw_lanes u_lanes (
        .byte_off  (eff_addr[1:0]),
        .size_code (h_size),
        .wr_data   (h_wdata),
        .rd_word   (lane_src),
        .byte_en   (rb_be),
        .wr_lanes  (wr_lanes),
        .wr_bits   (wr_bits),
        .rd_aligned(rd_aligned)
    );

    // Drive the bank and memory strobes for the routed access.
    always_comb begin
        rb_req    = h_req && (target == TGT_BANK);
        rb_wr     = h_wr;
        rb_addr   = eff_addr;
        rb_wdata  = wr_lanes;
        mem_req   = h_req && (target == TGT_MEM);
        mem_wr    = h_wr;
        mem_size  = h_size;
        mem_wdata = h_wdata & size_mask(h_size);
        lane_src  = (target == TGT_INDEX) ? idx_q : rb_rdata;
    end

    // Select the read result for the routed target.
    always_comb begin
        case (target)
            TGT_INDEX: rd_mux = rd_aligned;
            TGT_BANK:  rd_mux = rb_hit ? rd_aligned : 32'd0;
            TGT_MEM:   rd_mux = mem_rdata & size_mask(h_size);
            default:   rd_mux = 32'd0;
        endcase
    end

    // Pointer register with byte-lane merge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= 32'd0;
        else if (h_req && h_wr && target == TGT_INDEX)
            idx_q <= (idx_q & ~wr_bits) | wr_lanes;
    end

    // Registered read response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rvalid <= 1'b0;
            h_rdata  <= 32'd0;
        end else begin
            h_rvalid <= h_req && !h_wr;
            if (h_req && !h_wr)
                h_rdata <= rd_mux;
        end
    end

    // R2
    idx_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && h_wr && h_addr == '0 && h_size == SZ_WORD) |=> (idx_q == $past(h_wdata)));

    // R3
    resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (h_req && !h_wr) |=> h_rvalid);

    // R4
    mem_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (idx_q[31] && h_addr[ADDR_W-1:2] == WIN_W));

    // R5
    mem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((32'(mem_addr) + (32'd1 << mem_size)) <= 32'(MEM_BYTES)));

    // R10
    win_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_req |-> (rb_addr[ADDR_W-1:2] != WIN_W));

    // R6
    one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rb_req && mem_req));

endmodule

// File: tb/sim_idx_window.sv
module sim_idx_window;

    localparam int ADDR_W    = 12;
    localparam int MEM_BYTES = 256;
    localparam int MEM_AW    = 8;
    localparam int NVEC      = 46;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [1:0]  size;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 12'h000, 2'd2, 32'h12345678, 32'h0,        4'd2},  // R2
        '{1'b0, 12'h000, 2'd2, 32'h0,        32'h12345678, 4'd2},  // R2
        '{1'b0, 12'h001, 2'd0, 32'h0,        32'h00000056, 4'd12}, // R12
        '{1'b0, 12'h002, 2'd1, 32'h0,        32'h00001234, 4'd12}, // R12
        '{1'b1, 12'h010, 2'd2, 32'hAABBCCDD, 32'h0,        4'd6},  // R6
        '{1'b0, 12'h010, 2'd2, 32'h0,        32'hAABBCCDD, 4'd6},  // R6
        '{1'b0, 12'h011, 2'd0, 32'h0,        32'h000000CC, 4'd7},  // R7
        '{1'b0, 12'h012, 2'd1, 32'h0,        32'h0000AABB, 4'd7},  // R7
        '{1'b1, 12'h013, 2'd0, 32'h000000EE, 32'h0,        4'd8},  // R8
        '{1'b0, 12'h010, 2'd2, 32'h0,        32'hEEBBCCDD, 4'd8},  // R8
        '{1'b1, 12'h010, 2'd1, 32'hFFFF1122, 32'h0,        4'd8},  // R8
        '{1'b0, 12'h010, 2'd2, 32'h0,        32'hEEBB1122, 4'd8},  // R8
        '{1'b0, 12'h020, 2'd2, 32'h0,        32'h0,        4'd9},  // R9
        '{1'b1, 12'h020, 2'd2, 32'h77777777, 32'h0,        4'd9},  // R9
        '{1'b0, 12'h014, 2'd2, 32'h0,        32'h0,        4'd9},  // R9
        '{1'b0, 12'h013, 2'd1, 32'h0,        32'h0,        4'd11}, // R11
        '{1'b1, 12'h012, 2'd2, 32'h99999999, 32'h0,        4'd11}, // R11
        '{1'b0, 12'h010, 2'd2, 32'h0,        32'hEEBB1122, 4'd11}, // R11
        '{1'b0, 12'h010, 2'd3, 32'h0,        32'h0,        4'd11}, // R11
        '{1'b1, 12'h000, 2'd2, 32'h00000014, 32'h0,        4'd6},  // R6
        '{1'b1, 12'h004, 2'd2, 32'h01020304, 32'h0,        4'd6},  // R6
        '{1'b0, 12'h014, 2'd2, 32'h0,        32'h01020304, 4'd6},  // R6
        '{1'b1, 12'h000, 2'd2, 32'h00000010, 32'h0,        4'd6},  // R6
        '{1'b0, 12'h006, 2'd1, 32'h0,        32'h0000EEBB, 4'd6},  // R6
        '{1'b0, 12'h005, 2'd0, 32'h0,        32'h00000011, 4'd6},  // R6
        '{1'b1, 12'h000, 2'd2, 32'h00000004, 32'h0,        4'd10}, // R10
        '{1'b0, 12'h004, 2'd2, 32'h0,        32'h0,        4'd10}, // R10
        '{1'b1, 12'h004, 2'd2, 32'h0000DEAD, 32'h0,        4'd10}, // R10
        '{1'b0, 12'h000, 2'd2, 32'h0,        32'h00000004, 4'd10}, // R10
        '{1'b1, 12'h000, 2'd2, 32'h10000010, 32'h0,        4'd10}, // R10
        '{1'b0, 12'h004, 2'd2, 32'h0,        32'h0,        4'd10}, // R10
        '{1'b1, 12'h000, 2'd2, 32'h80000000, 32'h0,        4'd4},  // R4
        '{1'b0, 12'h004, 2'd2, 32'h0,        32'hA6A7A4A5, 4'd4},  // R4
        '{1'b1, 12'h000, 2'd2, 32'h80000020, 32'h0,        4'd4},  // R4
        '{1'b1, 12'h004, 2'd2, 32'h44332211, 32'h0,        4'd4},  // R4
        '{1'b0, 12'h004, 2'd0, 32'h0,        32'h00000011, 4'd4},  // R4
        '{1'b0, 12'h006, 2'd1, 32'h0,        32'h00004433, 4'd4},  // R4
        '{1'b0, 12'h005, 2'd0, 32'h0,        32'h00000022, 4'd4},  // R4
        '{1'b1, 12'h000, 2'd2, 32'h800000FC, 32'h0,        4'd5},  // R5
        '{1'b0, 12'h004, 2'd2, 32'h0,        32'h5A5B5859, 4'd5},  // R5
        '{1'b0, 12'h005, 2'd2, 32'h0,        32'h0,        4'd5},  // R5
        '{1'b0, 12'h007, 2'd0, 32'h0,        32'h0000005A, 4'd5},  // R5
        '{1'b1, 12'h005, 2'd2, 32'hFFFFFFFF, 32'h0,        4'd5},  // R5
        '{1'b0, 12'h004, 2'd2, 32'h0,        32'h5A5B5859, 4'd5},  // R5
        '{1'b1, 12'h000, 2'd2, 32'h80000100, 32'h0,        4'd5},  // R5
        '{1'b0, 12'h004, 2'd0, 32'h0,        32'h0,        4'd5}   // R5
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              h_req = 1'b0;
    logic              h_wr = 1'b0;
    logic [ADDR_W-1:0] h_addr = '0;
    logic [1:0]        h_size = 2'd2;
    logic [31:0]       h_wdata = 32'd0;
    logic [31:0]       h_rdata;
    logic              h_rvalid;
    logic              rb_req;
    logic              rb_wr;
    logic [ADDR_W-1:0] rb_addr;
    logic [3:0]        rb_be;
    logic [31:0]       rb_wdata;
    logic [31:0]       rb_rdata;
    logic              rb_hit;
    logic              mem_req;
    logic              mem_wr;
    logic [MEM_AW-1:0] mem_addr;
    logic [1:0]        mem_size;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    idx_window #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u0 (
        .clk(clk), .rst_n(rst_n),
        .h_req(h_req), .h_wr(h_wr), .h_addr(h_addr), .h_size(h_size),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
        .rb_req(rb_req), .rb_wr(rb_wr), .rb_addr(rb_addr), .rb_be(rb_be),
        .rb_wdata(rb_wdata), .rb_rdata(rb_rdata), .rb_hit(rb_hit),
        .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Register bank stub: four registers at byte addresses 0x10..0x1F.
    logic [31:0] bank [4];
    assign rb_hit   = rb_addr[ADDR_W-1:4] == 8'h01;
    assign rb_rdata = rb_hit ? bank[rb_addr[3:2]] : 32'hDEAD_BEEF;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) bank[i] <= 32'd0;
        end else if (rb_req && rb_wr && rb_hit) begin
            for (int b = 0; b < 4; b++)
                if (rb_be[b]) bank[rb_addr[3:2]][8*b +: 8] <= rb_wdata[8*b +: 8];
        end
    end

    // Memory stub: byte array, preset to (address XOR 0xA5).
    logic [7:0] mem [MEM_BYTES];
    always_comb begin
        for (int k = 0; k < 4; k++)
            mem_rdata[8*k +: 8] = mem[8'(mem_addr + 8'(k))];
    end
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'(i) ^ 8'hA5;
        end else if (mem_req && mem_wr) begin
            for (int k = 0; k < 4; k++)
                if (k < (1 << mem_size)) mem[8'(mem_addr + 8'(k))] <= mem_wdata[8*k +: 8];
        end
    end

    task automatic check(input bit ok, input int rq, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // One host access; the response is sampled at the next falling edge.
    task automatic host_op(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                           input logic [31:0] d, input logic [31:0] exp, input int rq);
        @(negedge clk);
        h_req = 1'b1; h_wr = wr; h_addr = a; h_size = sz; h_wdata = d;
        @(negedge clk);
        h_req = 1'b0; h_wr = 1'b0;
        if (wr)
            check(!h_rvalid, 3, 32'(h_rvalid), 32'd0, "rvalid after write"); // R3
        else begin
            check(h_rvalid, 3, 32'(h_rvalid), 32'd1, "rvalid after read");   // R3
            check(h_rdata == exp, rq, h_rdata, exp, $sformatf("read at %h", a));
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(h_rvalid == 1'b0, 1, 32'(h_rvalid), 32'd0, "rvalid after reset");
        check(h_rdata == 32'd0, 1, h_rdata, 32'd0, "rdata after reset");
        host_op(1'b0, 12'h000, 2'd2, 32'd0, 32'd0, 1); // R1 pointer is zero

        for (int v = 0; v < NVEC; v++)
            host_op(VEC[v].wr, VEC[v].addr, VEC[v].size, VEC[v].data, VEC[v].exp, int'(VEC[v].req));

        // R3: idle cycle after a read drops rvalid and holds data
        host_op(1'b0, 12'h010, 2'd2, 32'd0, 32'hEEBB1122, 3);
        @(negedge clk);
        check(h_rvalid == 1'b0, 3, 32'(h_rvalid), 32'd0, "rvalid after idle");
        check(h_rdata == 32'hEEBB1122, 3, h_rdata, 32'hEEBB1122, "rdata held");

        // R1: reset in mid-run clears the pointer
        host_op(1'b1, 12'h000, 2'd2, 32'hCAFEF00D, 32'd0, 2);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(h_rvalid == 1'b0, 1, 32'(h_rvalid), 32'd0, "rvalid after second reset");
        host_op(1'b0, 12'h000, 2'd2, 32'd0, 32'd0, 1); // R1

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule